// File: doc/BRIEF.md
# LCD Multiplex Scan and Blink Timing Generator

This block produces the digital drive timing for a segment LCD run at 1/4 duty: four common lines and twenty-seven segment lines. From a single input clock it divides out a frame of one of four lengths and splits each frame into four equal common phases. For every common and every segment it emits a 2-bit drive-level code each cycle, and an analog stage outside the block turns that code into a voltage. The polarity follows either per-line or per-frame inversion, the bias select picks the intermediate codes, and a frame-counting blink timer blanks the segments on a slow cadence.

Configuration arrives as static register values. Segment on/off bits arrive as one flat word holding four bits per segment, which is the display RAM contents for the visible segment addresses. The all-pixel overrides and the blink blank are combined with a fixed priority. A configuration bit turns the display on or off, and the change is applied only at a frame boundary. A separate panel-enable pin blanks the outputs at once, without waiting for the frame to end.

Top module: `lcd_scan_timer`

## Requirements
- R1: `rateSel` selects the frame length: code 0 gives 512 clocks, code 1 gives 576, code 2 gives 648 and code 3 gives 768. The code is sampled only at the end of a frame. Code 0 is in effect from reset until the first frame end.
- R2: A frame has four phases of equal length (frame length / 4) that select common 0, 1, 2 and 3 in that order, starting at common 0 after reset. While driving, the selected common is at code 3 when polarity is 0 and at code 0 when polarity is 1. Each other common is at code 1 when polarity is 0 and at code 2 when polarity is 1.
- R3: With `frameInvert`=0 (line inversion), polarity toggles at the end of every phase. Polarity is 0 after reset.
- R4: With `frameInvert`=1 (frame inversion), polarity toggles only at the end of the last phase of a frame.
- R5: Segment s shows bit `segBits[4*s + c]` during phase c. An on segment is driven to the rail opposite its common: code 0 at polarity 0, code 3 at polarity 1. An off segment is driven to code 2 at polarity 0 and code 1 at polarity 1.
- R6: With `halfBias`=1, every output that would carry code 2 carries code 1 instead, because both intermediate levels are one midpoint.
- R7: `blinkSel` 0 disables blinking and holds the frame counter at 0. Codes 1, 2 and 3 give half-periods of BLINK_HALF1, BLINK_HALF2 and BLINK_HALF3 frames. The counter advances at each frame end and wraps to 0 when it reaches twice the half-period. While the count is at or above the half-period, every segment is off.
- R8: Segment priority, highest first: `forceOff` or the blink blank forces off, then `forceOn` forces on, then the RAM bit decides. If `forceOn` and `forceOff` are both set, the segments are off.
- R9: `dispOnCfg` is sampled only at a frame end into the display state, which is off after reset. A change therefore reaches the outputs at the start of the next frame.
- R10: When `panelEnable` is 0, the outputs show the off-state values in the same cycle, whatever the phase.
- R11: In the off state every segment and every common carries code 0 (the low LCD supply level). Commons 1 to 3 also assert their `comGround` bit (driver tied to ground) and common 0 does not. `forceOn`, `forceOff` and `segBits` have no effect in the off state. While driving, `comGround` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rstN | input | 1 | Asynchronous active-low reset |
| panelEnable | input | 1 | 1 lets the outputs drive; 0 blanks them at once |
| dispOnCfg | input | 1 | Display-on configuration bit, applied at a frame end |
| halfBias | input | 1 | 1 selects 1/2 bias, 0 selects 1/3 bias |
| rateSel | input | 2 | Frame length select |
| frameInvert | input | 1 | 1 selects frame inversion, 0 selects line inversion |
| blinkSel | input | 2 | Blink rate select (0 = off) |
| forceOn | input | 1 | All segments on |
| forceOff | input | 1 | All segments off (wins over forceOn) |
| segBits | input | SEGS*COMS | RAM nibbles, 4 bits per segment |
| comLevel | output | COMS*2 | Level code per common |
| comGround | output | COMS | Per-common ground tie in the off state |
| segLevel | output | SEGS*2 | Level code per segment |

## Verification
Two functions can meet at the same frame boundary: the blink counter crossing into its blanked half, and an all-pixel-on override that is already active. The bench keeps `forceOn` set while the fastest blink rate runs through several frames, and it checks cycle by cycle that the segments drop to the off code exactly when the blank starts. It also drops `panelEnable` partway through a phase and checks that the off-state codes appear on the very next sample. `dispOnCfg` is cleared partway through a frame, and the bench checks that driving continues until that frame ends.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  localparam logic [1:0] LVL_LOW   = 2'd0;
  localparam logic [1:0] LVL_MIDLO = 2'd1;
  localparam logic [1:0] LVL_MIDHI = 2'd2;
  localparam logic [1:0] LVL_HIGH  = 2'd3;

  typedef struct packed {
    logic phaseEnd;
    logic frameEnd;
    logic pol;
    logic active;
    logic blank;
  } scanStrobes_t;

  function automatic logic [1:0] biasMap(input logic [1:0] code, input logic half);
    return (half && code == LVL_MIDHI) ? LVL_MIDLO : code;
  endfunction

endpackage

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
  import lcdt_pkg::*;
#(
  parameter int COMS        = 4,
  parameter int FRAME_DIV0  = 512,
  parameter int FRAME_DIV1  = 576,
  parameter int FRAME_DIV2  = 648,
  parameter int FRAME_DIV3  = 768,
  parameter int BLINK_HALF1 = 80,
  parameter int BLINK_HALF2 = 40,
  parameter int BLINK_HALF3 = 20,
  localparam int CIW = (COMS > 1) ? $clog2(COMS) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     rateSel,
  input  logic           frameInvert,
  input  logic [1:0]     blinkSel,
  input  logic           dispOnCfg,
  output scanStrobes_t   strobes,
  output logic [CIW-1:0] comIdx
);

  localparam int DMAX01 = (FRAME_DIV0 > FRAME_DIV1) ? FRAME_DIV0 : FRAME_DIV1;
  localparam int DMAX23 = (FRAME_DIV2 > FRAME_DIV3) ? FRAME_DIV2 : FRAME_DIV3;
  localparam int DMAX   = (DMAX01 > DMAX23) ? DMAX01 : DMAX23;
  localparam int PW     = $clog2(DMAX / COMS + 1);
  localparam int BMAX12 = (BLINK_HALF1 > BLINK_HALF2) ? BLINK_HALF1 : BLINK_HALF2;
  localparam int BMAX   = (BMAX12 > BLINK_HALF3) ? BMAX12 : BLINK_HALF3;
  localparam int BW     = $clog2(2 * BMAX + 1);

  logic [1:0]     rateShadow;
  logic [PW-1:0]  phaseCnt;
  logic [PW-1:0]  phaseLast;
  logic [BW-1:0]  blinkCnt;
  logic [BW-1:0]  blinkHalf;
  logic [BW-1:0]  blinkNext;
  logic           pol;
  logic           active;
  logic           phaseEnd;
  logic           frameEnd;
  logic           lastCom;

  always_comb begin
    case (rateShadow)
      2'd0:    phaseLast = PW'(FRAME_DIV0 / COMS - 1);
      2'd1:    phaseLast = PW'(FRAME_DIV1 / COMS - 1);
      2'd2:    phaseLast = PW'(FRAME_DIV2 / COMS - 1);
      default: phaseLast = PW'(FRAME_DIV3 / COMS - 1);
    endcase
  end

  assign phaseEnd = (phaseCnt == phaseLast);
  assign lastCom  = (comIdx == CIW'(COMS - 1));
  assign frameEnd = phaseEnd && lastCom;

  always_comb begin
    case (blinkSel)
      2'd1:    blinkHalf = BW'(BLINK_HALF1);
      2'd2:    blinkHalf = BW'(BLINK_HALF2);
      2'd3:    blinkHalf = BW'(BLINK_HALF3);
      default: blinkHalf = '0;
    endcase
    if (blinkSel == 2'd0)
      blinkNext = '0;
    else if ((blinkCnt + BW'(1)) >= (blinkHalf << 1))
      blinkNext = '0;
    else
      blinkNext = blinkCnt + BW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt   <= '0;
      comIdx     <= '0;
      pol        <= 1'b0;
      rateShadow <= 2'd0;
      blinkCnt   <= '0;
      active     <= 1'b0;
    end else begin
      if (phaseEnd) begin
        phaseCnt <= '0;
        comIdx   <= lastCom ? '0 : comIdx + CIW'(1);
      end else begin
        phaseCnt <= phaseCnt + PW'(1);
      end
      if ((!frameInvert && phaseEnd) || (frameInvert && frameEnd))
        pol <= ~pol;
      if (frameEnd) begin
        rateShadow <= rateSel;
        active     <= dispOnCfg;
        blinkCnt   <= blinkNext;
      end
    end
  end

  always_comb begin
    strobes.phaseEnd = phaseEnd;
    strobes.frameEnd = frameEnd;
    strobes.pol      = pol;
    strobes.active   = active;
    strobes.blank    = (blinkSel != 2'd0) && (blinkCnt >= blinkHalf);
  end

endmodule

// File: rtl/lcdt_datapath.sv
module lcdt_datapath
  import lcdt_pkg::*;
#(
  parameter int SEGS = 27,
  parameter int COMS = 4,
  localparam int CIW = (COMS > 1) ? $clog2(COMS) : 1
) (
  input  scanStrobes_t       strobes,
  input  logic [CIW-1:0]     comIdx,
  input  logic               panelEnable,
  input  logic               halfBias,
  input  logic               forceOn,
  input  logic               forceOff,
  input  logic [SEGS*COMS-1:0] segBits,
  output logic [COMS*2-1:0]  comLevel,
  output logic [COMS-1:0]    comGround,
  output logic [SEGS*2-1:0]  segLevel
);

  logic drive;
  logic segKill;
  logic unusedStrobeBits;

  assign drive            = strobes.active && panelEnable;
  assign segKill          = forceOff || strobes.blank;
  assign unusedStrobeBits = strobes.phaseEnd ^ strobes.frameEnd;

  for (genvar c = 0; c < COMS; c++) begin : gCom
    always_comb begin
      if (!drive) begin
        comLevel[2*c +: 2] = LVL_LOW;
        comGround[c]       = (c != 0);
      end else begin
        comGround[c] = 1'b0;
        if (comIdx == CIW'(c))
          comLevel[2*c +: 2] = strobes.pol ? LVL_LOW : LVL_HIGH;
        else
          comLevel[2*c +: 2] = biasMap(strobes.pol ? LVL_MIDHI : LVL_MIDLO, halfBias);
      end
    end
  end

  for (genvar s = 0; s < SEGS; s++) begin : gSeg
    logic [COMS-1:0] nibble;
    logic            lit;
    assign nibble = segBits[s*COMS +: COMS];
    assign lit    = !segKill && (forceOn || nibble[comIdx]);
    always_comb begin
      if (!drive)
        segLevel[2*s +: 2] = LVL_LOW;
      else if (lit)
        segLevel[2*s +: 2] = strobes.pol ? LVL_HIGH : LVL_LOW;
      else
        segLevel[2*s +: 2] = biasMap(strobes.pol ? LVL_MIDLO : LVL_MIDHI, halfBias);
    end
  end

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcdt_pkg::*;
#(
  parameter int SEGS        = 27,
  parameter int COMS        = 4,
  parameter int FRAME_DIV0  = 512,
  parameter int FRAME_DIV1  = 576,
  parameter int FRAME_DIV2  = 648,
  parameter int FRAME_DIV3  = 768,
  parameter int BLINK_HALF1 = 80,
  parameter int BLINK_HALF2 = 40,
  parameter int BLINK_HALF3 = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 panelEnable,
  input  logic                 dispOnCfg,
  input  logic                 halfBias,
  input  logic [1:0]           rateSel,
  input  logic                 frameInvert,
  input  logic [1:0]           blinkSel,
  input  logic                 forceOn,
  input  logic                 forceOff,
  input  logic [SEGS*COMS-1:0] segBits,
  output logic [COMS*2-1:0]    comLevel,
  output logic [COMS-1:0]      comGround,
  output logic [SEGS*2-1:0]    segLevel
);

  localparam int CIW = (COMS > 1) ? $clog2(COMS) : 1;

  scanStrobes_t   strobes;
  logic [CIW-1:0] comIdx;

  lcdt_ctrl #(
    .COMS(COMS), .FRAME_DIV0(FRAME_DIV0), .FRAME_DIV1(FRAME_DIV1),
    .FRAME_DIV2(FRAME_DIV2), .FRAME_DIV3(FRAME_DIV3),
    .BLINK_HALF1(BLINK_HALF1), .BLINK_HALF2(BLINK_HALF2), .BLINK_HALF3(BLINK_HALF3)
  ) ctrl (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .frameInvert(frameInvert),
    .blinkSel(blinkSel), .dispOnCfg(dispOnCfg), .strobes(strobes), .comIdx(comIdx)
  );

  lcdt_datapath #(.SEGS(SEGS), .COMS(COMS)) dpath (
    .strobes(strobes), .comIdx(comIdx), .panelEnable(panelEnable),
    .halfBias(halfBias), .forceOn(forceOn), .forceOff(forceOff),
    .segBits(segBits), .comLevel(comLevel), .comGround(comGround),
    .segLevel(segLevel)
  );

endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk
  import lcdt_pkg::*;
#(
  parameter int SEGS = 27,
  parameter int COMS = 4,
  localparam int CIW = (COMS > 1) ? $clog2(COMS) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               panelEnable,
  input logic               frameInvert,
  input logic               forceOff,
  input logic               halfBias,
  input logic [SEGS*2-1:0]  segLevel,
  input logic [COMS-1:0]    comGround,
  input scanStrobes_t       strobes,
  input logic [CIW-1:0]     comIdx
);

  localparam logic [COMS-1:0] GND_MASK = {{(COMS-1){1'b1}}, 1'b0};

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.phaseEnd |=> $stable(comIdx));

  // R3
  line_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.phaseEnd && !frameInvert) |=> (strobes.pol != $past(strobes.pol)));

  // R9
  frame_aligned_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.frameEnd |=> $stable(strobes.active));

  // R8
  seg_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.active && panelEnable && (forceOff || strobes.blank) && !halfBias && !strobes.pol)
      |-> (segLevel == {SEGS{LVL_MIDHI}}));

  // R10
  pin_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    !panelEnable |-> (segLevel == '0 && comGround == GND_MASK));

endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(.SEGS(SEGS), .COMS(COMS)) chk (
  .clk(clk), .rstN(rstN), .panelEnable(panelEnable), .frameInvert(frameInvert),
  .forceOff(forceOff), .halfBias(halfBias), .segLevel(segLevel),
  .comGround(comGround), .strobes(strobes), .comIdx(comIdx)
);

// File: tb/lcd_scan_timer_test.sv
`timescale 1ns/100ps
module lcd_scan_timer_test;
  localparam int SEGS = 27;
  localparam int COMS = 4;
  localparam int SB   = SEGS * COMS;
  localparam int DIV [4] = '{512, 576, 648, 768};
  localparam int HALF[4] = '{0, 3, 2, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic panelEnable = 1'b1, dispOnCfg = 1'b0, halfBias = 1'b0, frameInvert = 1'b0;
  logic forceOn = 1'b0, forceOff = 1'b0;
  logic [1:0] rateSel = 2'd0, blinkSel = 2'd0;
  logic [SB-1:0] segBits = '0;
  logic [COMS*2-1:0] comLevel;
  logic [COMS-1:0]   comGround;
  logic [SEGS*2-1:0] segLevel;

  int checks = 0, failures = 0;
  bit cmpOn = 0, finished = 0;
  string curReq = "R11";

  int mPc = 0, mCi = 0, mPol = 0, mSel = 0, mAct = 0, mBc = 0;

  lcd_scan_timer #(.SEGS(SEGS), .COMS(COMS),
    .BLINK_HALF1(3), .BLINK_HALF2(2), .BLINK_HALF3(1)) uut (
    .clk(clk), .rstN(rstN), .panelEnable(panelEnable), .dispOnCfg(dispOnCfg),
    .halfBias(halfBias), .rateSel(rateSel), .frameInvert(frameInvert),
    .blinkSel(blinkSel), .forceOn(forceOn), .forceOff(forceOff),
    .segBits(segBits), .comLevel(comLevel), .comGround(comGround),
    .segLevel(segLevel));

  always #2.5 clk = ~clk;

  // behavioural reference of the scan state
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPc = 0; mCi = 0; mPol = 0; mSel = 0; mAct = 0; mBc = 0;
    end else begin
      int plen;
      bit pe, fe;
      plen = DIV[mSel] / COMS;
      pe = (mPc == plen - 1);
      fe = pe && (mCi == COMS - 1);
      if (pe) begin mPc = 0; mCi = (mCi + 1) % COMS; end
      else mPc = mPc + 1;
      if ((!frameInvert && pe) || (frameInvert && fe)) mPol = 1 - mPol;
      if (fe) begin
        mSel = rateSel;
        mAct = dispOnCfg;
        if (blinkSel == 0) mBc = 0;
        else begin
          mBc = mBc + 1;
          if (mBc >= 2 * HALF[blinkSel]) mBc = 0;
        end
      end
    end
  end

  function automatic logic [1:0] bmap(int code);
    return (halfBias && code == 2) ? 2'd1 : 2'(code);
  endfunction

  task automatic report(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn) begin
      logic [COMS*2-1:0] eCom;
      logic [COMS-1:0]   eGnd;
      logic [SEGS*2-1:0] eSeg;
      bit drive, blank, lit;
      drive = (mAct != 0) && panelEnable;
      blank = (blinkSel != 0) && (mBc >= HALF[blinkSel]);
      for (int c = 0; c < COMS; c++) begin
        if (!drive) begin eCom[2*c +: 2] = 2'd0; eGnd[c] = (c != 0); end
        else begin
          eGnd[c] = 1'b0;
          if (c == mCi) eCom[2*c +: 2] = mPol ? 2'd0 : 2'd3;
          else eCom[2*c +: 2] = bmap(mPol ? 2 : 1);
        end
      end
      for (int s = 0; s < SEGS; s++) begin
        lit = !forceOff && !blank && (forceOn || segBits[s*COMS + mCi]);
        if (!drive) eSeg[2*s +: 2] = 2'd0;
        else if (lit) eSeg[2*s +: 2] = mPol ? 2'd3 : 2'd0;
        else eSeg[2*s +: 2] = bmap(mPol ? 1 : 2);
      end
      report(curReq, "comLevel", 128'(comLevel), 128'(eCom));
      report(curReq, "comGround", 128'(comGround), 128'(eGnd));
      report(curReq, "segLevel", 128'(segLevel), 128'(eSeg));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic newBits();
    segBits = SB'({$urandom(), $urandom(), $urandom(), $urandom()});
  endtask

  initial begin
    cyc(4);
    rstN = 1'b1;
    cmpOn = 1;
    newBits();
    // reset state: R9 display off, R11 off-state codes
    cyc(3);
    @(negedge clk);
    report("R11", "reset segLevel", 128'(segLevel), 128'(0));
    report("R9", "reset comGround", 128'(comGround), 128'(4'b1110));
    cyc(1);
    forceOn = 1'b1; curReq = "R11";
    cyc(200);
    @(negedge clk);
    report("R11", "force while off", 128'(segLevel), 128'(0));
    cyc(1);
    forceOn = 1'b0;
    curReq = "R9"; dispOnCfg = 1'b1;
    cyc(600);
    curReq = "R2";
    cyc(550); newBits();
    curReq = "R5";
    cyc(550); newBits();
    curReq = "R3";
    cyc(700);
    curReq = "R4"; frameInvert = 1'b1;
    cyc(800); newBits(); cyc(900);
    curReq = "R1";
    rateSel = 2'd1; cyc(1300); newBits();
    rateSel = 2'd2; cyc(1400); frameInvert = 1'b0;
    rateSel = 2'd3; cyc(1700); newBits();
    rateSel = 2'd0; cyc(900);
    curReq = "R6"; halfBias = 1'b1;
    cyc(600); frameInvert = 1'b1; cyc(600); halfBias = 1'b0;
    curReq = "R7";
    blinkSel = 2'd1; cyc(512 * 7); newBits();
    blinkSel = 2'd2; cyc(512 * 5);
    blinkSel = 2'd3; cyc(512 * 3);
    blinkSel = 2'd0; cyc(700);
    curReq = "R8";
    forceOn = 1'b1; cyc(600);
    forceOff = 1'b1; cyc(600);
    forceOn = 1'b0; cyc(300);
    forceOff = 1'b0; forceOn = 1'b1; blinkSel = 2'd3; cyc(512 * 4);
    forceOn = 1'b0; blinkSel = 2'd0; cyc(300);
    curReq = "R10";
    cyc(37);
    panelEnable = 1'b0;
    @(negedge clk);
    report("R10", "immediate comGround", 128'(comGround), 128'(4'b1110));
    cyc(250);
    panelEnable = 1'b1;
    cyc(300);
    curReq = "R9";
    cyc(71);
    dispOnCfg = 1'b0;
    cyc(1200);
    curReq = "R11"; forceOn = 1'b1; newBits();
    cyc(400);
    cmpOn = 0;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule